// File: doc/BRIEF.md
# Raw VBI Line Capture Selector

This block sits behind a video decoder's sample path and decides, for every video line, whether that line is handed on as raw vertical-blanking data. A line is taken when its field is enabled and it passes either the all-lines test (any line that carries no equalization or serration pulses) or the per-line mask test. For a taken line, the block waits a programmable number of sample pairs after the horizontal sync edge and then passes the incoming sample bytes to its output. It can first insert a four-byte header that identifies the line number and field, with the two identifying bytes protected by parity.

The control fields are copied into a shadow at every sync pulse. A line is judged with the shadow content that was present when its own sync pulse arrived. A control change therefore acts from the line after the one in which it was written. The output byte stream is registered and carries a valid strobe and a start-of-line marker.

Top module: `vbi_line_capture`

## Requirements
- R1: A line with field flag 0 (odd) is captured only if the odd enable is set. A line with field flag 1 (even) is captured only if the even enable is set. This holds in both selection modes.
- R2: In all-lines mode, every line of an enabled field is captured unless the equalization/serration flag is high at its sync pulse.
- R3: In mask mode, a line is captured only if its number is below 32 and the mask bit indexed by the line number's low five bits is 1. The equalization flag plays no part in mask mode.
- R4: On a captured line, the first 2*start valid samples after the sync pulse are skipped. Output begins on valid sample number 2*start, counting from 0. A start of 0 gives output from the first sample.
- R5: With header enable set, the first four output bytes of a captured line are 0xFF, CNT1, CNT2, 0x00, on consecutive valid samples. The sample bytes follow, the first of them being the sample present at the fifth output slot.
- R6: CNT1 has bit 7 equal to NOT p and bit 6 equal to p, where p is the XOR of bits 5..0. Bit 5 is the field flag and bits 4..0 are line number bits 8..4.
- R7: CNT2 has the same parity rule in bits 7 and 6. Bits 5 and 4 are 0 and bits 3..0 are line number bits 3..0.
- R8: After reset the outputs are 0 and the shadow holds start 0x7A with all enables and the header off. The line that begins at the first sync pulse after reset is therefore never captured.
- R9: out_sol is high together with out_valid on the first output byte of a captured line only, whether that byte is 0xFF or a sample.
- R10: A sync pulse ends the current line's capture. No byte is output in the cycle after a sync pulse, and later samples belong to the new line's decision.
- R11: Control inputs present at a sync pulse take effect for the line that begins at the following sync pulse.
- R12: Each output byte appears one clock after the valid sample that produced it. A sample byte is passed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Sample byte |
| hs_pulse | input | 1 | One-cycle pulse at the sync leading edge |
| field_even | input | 1 | Field flag, 0 odd, 1 even |
| line_num | input | 9 | Line number of the line starting at hs_pulse |
| eq_line | input | 1 | Line carries equalization or serration pulses |
| ctl_all | input | 1 | All-lines mode (1) or mask mode (0) |
| ctl_odd_en | input | 1 | Capture odd-field lines |
| ctl_even_en | input | 1 | Capture even-field lines |
| ctl_pre_en | input | 1 | Insert four-byte header |
| ctl_start | input | 8 | Start delay in pairs of valid samples |
| ctl_mask | input | 32 | Per-line capture mask |
| out_byte | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_sol | output | 1 | First byte of a captured line |

## Verification
The bench builds the block with its default parameters: a 9-bit line number, a 32-entry mask and an 8-bit start count. Keeping the start delay small lets each directed line reach both the header and the sample stream within a few dozen samples. The 9-bit line range lets the bench test a line such as 37, whose low bits alias a set mask bit and which must still be refused. Line numbers with odd and even parity payloads exercise both polarities of the header's guard bits. Gapped sample strobes show that the delay and the header advance only on valid samples.

// File: rtl/vbi_cap_pkg.sv
package vbi_cap_pkg;

  localparam int VBI_LINE_W  = 9;
  localparam int VBI_MASK_W  = 32;
  localparam int VBI_START_W = 8;
  localparam int VBI_DATA_W  = 8;

  localparam logic [7:0] HDR_LEAD = 8'hFF;
  localparam logic [7:0] HDR_TAIL = 8'h00;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_HDR,
    PH_DATA
  } vbi_phase_e;

  // Guard bits: bit 6 is the even parity of the payload, bit 7 its inverse.
  function automatic logic [7:0] guard_byte(input logic [5:0] payload);
    logic p;
    p = ^payload;
    return {~p, p, payload};
  endfunction

endpackage

// File: rtl/vbi_ctl_shadow.sv
module vbi_ctl_shadow #(
  parameter int START_W = 8,
  parameter int MASK_W  = 32,
  parameter logic [START_W-1:0] START_RST = 8'h7A
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               in_all,
  input  logic               in_odd,
  input  logic               in_even,
  input  logic               in_hdr,
  input  logic [START_W-1:0] in_start,
  input  logic [MASK_W-1:0]  in_mask,
  output logic               sh_all,
  output logic               sh_odd,
  output logic               sh_even,
  output logic               sh_hdr,
  output logic [START_W-1:0] sh_start,
  output logic [MASK_W-1:0]  sh_mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_all   <= 1'b0;
      sh_odd   <= 1'b0;
      sh_even  <= 1'b0;
      sh_hdr   <= 1'b0;
      sh_start <= START_RST;
      sh_mask  <= '0;
    end else if (load) begin
      sh_all   <= in_all;
      sh_odd   <= in_odd;
      sh_even  <= in_even;
      sh_hdr   <= in_hdr;
      sh_start <= in_start;
      sh_mask  <= in_mask;
    end
  end

endmodule

// File: rtl/vbi_line_select.sv
module vbi_line_select #(
  parameter int LINE_W = 9,
  parameter int MASK_W = 32
) (
  input  logic              all_mode,
  input  logic              odd_en,
  input  logic              even_en,
  input  logic              field_even,
  input  logic              eq_line,
  input  logic [LINE_W-1:0] line_num,
  input  logic [MASK_W-1:0] mask,
  output logic              take
);

  localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

  logic field_ok;
  logic in_range;
  logic mask_hit;

  always_comb begin
    field_ok = field_even ? even_en : odd_en;
    in_range = (line_num < LINE_W'(MASK_W));
    mask_hit = in_range && mask[line_num[IDX_W-1:0]];
    take     = field_ok && (all_mode ? !eq_line : mask_hit);
  end

endmodule

// File: rtl/vbi_header_gen.sv
module vbi_header_gen #(
  parameter int LINE_W = 9
) (
  input  logic              field_even,
  input  logic [LINE_W-1:0] line_num,
  input  logic [1:0]        slot,
  output logic [7:0]        hdr_byte
);
  import vbi_cap_pkg::*;

  logic [7:0] table_q [4];
  logic [5:0] pay_hi;
  logic [5:0] pay_lo;

  always_comb begin
    pay_hi = {field_even, line_num[LINE_W-1:LINE_W-5]};
    pay_lo = {2'b00, line_num[3:0]};
  end

  for (genvar g = 0; g < 4; g++) begin : g_slot
    if (g == 0) begin : g_lead
      assign table_q[g] = HDR_LEAD;
    end else if (g == 1) begin : g_hi
      assign table_q[g] = guard_byte(pay_hi);
    end else if (g == 2) begin : g_lo
      assign table_q[g] = guard_byte(pay_lo);
    end else begin : g_tail
      assign table_q[g] = HDR_TAIL;
    end
  end

  assign hdr_byte = table_q[slot];

endmodule

// File: rtl/vbi_line_capture.sv
module vbi_line_capture #(
  parameter int LINE_W  = vbi_cap_pkg::VBI_LINE_W,
  parameter int MASK_W  = vbi_cap_pkg::VBI_MASK_W,
  parameter int START_W = vbi_cap_pkg::VBI_START_W,
  parameter int DATA_W  = vbi_cap_pkg::VBI_DATA_W,
  parameter logic [START_W-1:0] START_RST = 8'h7A
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid,
  input  logic [DATA_W-1:0]  smp_data,
  input  logic               hs_pulse,
  input  logic               field_even,
  input  logic [LINE_W-1:0]  line_num,
  input  logic               eq_line,
  input  logic               ctl_all,
  input  logic               ctl_odd_en,
  input  logic               ctl_even_en,
  input  logic               ctl_pre_en,
  input  logic [START_W-1:0] ctl_start,
  input  logic [MASK_W-1:0]  ctl_mask,
  output logic [DATA_W-1:0]  out_byte,
  output logic               out_valid,
  output logic               out_sol
);
  import vbi_cap_pkg::*;

  localparam int CNT_W = START_W + 1;

  logic               sh_all, sh_odd, sh_even, sh_hdr;
  logic [START_W-1:0] sh_start;
  logic [MASK_W-1:0]  sh_mask;
  logic               take;

  vbi_phase_e         phase;
  logic [CNT_W-1:0]   wait_cnt;
  logic [CNT_W-1:0]   dly_q;
  logic               hdr_q;
  logic [1:0]         slot_q;
  logic [LINE_W-1:0]  line_q;
  logic               field_q;
  logic [7:0]         hdr_byte;

  vbi_ctl_shadow #(
    .START_W(START_W), .MASK_W(MASK_W), .START_RST(START_RST)
  ) u_shadow (
    .clk(clk), .rst(rst), .load(hs_pulse),
    .in_all(ctl_all), .in_odd(ctl_odd_en), .in_even(ctl_even_en),
    .in_hdr(ctl_pre_en), .in_start(ctl_start), .in_mask(ctl_mask),
    .sh_all(sh_all), .sh_odd(sh_odd), .sh_even(sh_even),
    .sh_hdr(sh_hdr), .sh_start(sh_start), .sh_mask(sh_mask)
  );

  vbi_line_select #(
    .LINE_W(LINE_W), .MASK_W(MASK_W)
  ) u_select (
    .all_mode(sh_all), .odd_en(sh_odd), .even_en(sh_even),
    .field_even(field_even), .eq_line(eq_line), .line_num(line_num),
    .mask(sh_mask), .take(take)
  );

  vbi_header_gen #(
    .LINE_W(LINE_W)
  ) u_header (
    .field_even(field_q), .line_num(line_q), .slot(slot_q),
    .hdr_byte(hdr_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      wait_cnt  <= '0;
      dly_q     <= '0;
      hdr_q     <= 1'b0;
      slot_q    <= '0;
      line_q    <= '0;
      field_q   <= 1'b0;
      out_byte  <= '0;
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      if (hs_pulse) begin
        phase    <= take ? PH_WAIT : PH_IDLE;
        wait_cnt <= '0;
        slot_q   <= '0;
        dly_q    <= {sh_start, 1'b0};
        hdr_q    <= sh_hdr;
        line_q   <= line_num;
        field_q  <= field_even;
      end else if (smp_valid) begin
        unique case (phase)
          PH_WAIT: begin
            if (wait_cnt != dly_q) begin
              wait_cnt <= wait_cnt + 1'b1;
            end else begin
              out_valid <= 1'b1;
              out_sol   <= 1'b1;
              if (hdr_q) begin
                out_byte <= DATA_W'(hdr_byte);
                slot_q   <= 2'd1;
                phase    <= PH_HDR;
              end else begin
                out_byte <= smp_data;
                phase    <= PH_DATA;
              end
            end
          end
          PH_HDR: begin
            out_valid <= 1'b1;
            out_byte  <= DATA_W'(hdr_byte);
            slot_q    <= slot_q + 2'd1;
            if (slot_q == 2'd3) phase <= PH_DATA;
          end
          PH_DATA: begin
            out_valid <= 1'b1;
            out_byte  <= smp_data;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/vbi_line_capture_chk.sv
module vbi_line_capture_chk (
  input logic clk,
  input logic rst,
  input logic hs_pulse,
  input logic smp_valid,
  input logic out_valid,
  input logic out_sol
);

  logic [1:0] hs_seen;
  logic       sol_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_seen  <= '0;
      sol_seen <= 1'b0;
    end else begin
      if (hs_pulse && hs_seen != 2'd2) hs_seen <= hs_seen + 2'd1;
      if (hs_pulse) sol_seen <= 1'b0;
      else if (out_sol) sol_seen <= 1'b1;
    end
  end

  assert_sol_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> out_valid);

  assert_single_sol_R9: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> !sol_seen);

  assert_hsync_stops_R10: assert property (@(posedge clk) disable iff (rst)
    hs_pulse |=> !out_valid);

  assert_byte_from_sample_R12: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(smp_valid) && !$past(hs_pulse)));

  assert_first_line_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (hs_seen < 2'd2) |-> !out_valid);

endmodule

bind vbi_line_capture vbi_line_capture_chk u_chk (
  .clk(clk), .rst(rst), .hs_pulse(hs_pulse), .smp_valid(smp_valid),
  .out_valid(out_valid), .out_sol(out_sol)
);

// File: tb/vbi_line_capture_tb.sv
module vbi_line_capture_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [7:0]  smp_data = '0;
  logic        hs_pulse = 1'b0;
  logic        field_even = 1'b0;
  logic [8:0]  line_num = '0;
  logic        eq_line = 1'b0;
  logic        ctl_all = 1'b0, ctl_odd_en = 1'b0, ctl_even_en = 1'b0, ctl_pre_en = 1'b0;
  logic [7:0]  ctl_start = '0;
  logic [31:0] ctl_mask = '0;
  logic [7:0]  out_byte;
  logic        out_valid, out_sol;

  int checks = 0;
  int errors = 0;
  logic [7:0] cap_b [0:511];
  logic       cap_s [0:511];
  int cap_n = 0;

  always #10 clk = ~clk;

  vbi_line_capture u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .hs_pulse(hs_pulse), .field_even(field_even), .line_num(line_num),
    .eq_line(eq_line), .ctl_all(ctl_all), .ctl_odd_en(ctl_odd_en),
    .ctl_even_en(ctl_even_en), .ctl_pre_en(ctl_pre_en), .ctl_start(ctl_start),
    .ctl_mask(ctl_mask), .out_byte(out_byte), .out_valid(out_valid),
    .out_sol(out_sol)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && cap_n < 512) begin
      cap_b[cap_n] = out_byte;
      cap_s[cap_n] = out_sol;
      cap_n++;
    end
  end

  function automatic logic [7:0] guarded(input logic [5:0] pl);
    logic p;
    p = ^pl;
    return {~p, p, pl};
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic set_ctl(input bit a, input bit o, input bit e, input bit p,
                         input int s, input logic [31:0] m);
    ctl_all = a; ctl_odd_en = o; ctl_even_en = e; ctl_pre_en = p;
    ctl_start = 8'(s); ctl_mask = m;
  endtask

  task automatic hsync(input int ln, input bit fld, input bit eq);
    @(negedge clk);
    smp_valid = 1'b0; line_num = 9'(ln); field_even = fld; eq_line = eq; hs_pulse = 1'b1;
    @(negedge clk);
    hs_pulse = 1'b0;
  endtask

  task automatic feed(input int n, input bit gap, input int seed);
    for (int k = 0; k < n; k++) begin
      smp_valid = 1'b1; smp_data = 8'(seed + k);
      @(negedge clk);
      if (gap) begin
        smp_valid = 1'b0;
        @(negedge clk);
      end
    end
    smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // controls are loaded at a priming sync, then the measured line starts
  task automatic run_line(input bit a, input bit o, input bit e, input bit p,
                          input int s, input logic [31:0] m,
                          input int ln, input bit fld, input bit eq,
                          input int n, input bit gap, input int seed);
    set_ctl(a, o, e, p, s, m);
    hsync(ln, fld, eq);
    @(negedge clk);
    cap_n = 0;
    hsync(ln, fld, eq);
    feed(n, gap, seed);
  endtask

  task automatic expect_stream(input string tag, input int s, input int n,
                               input bit p, input int ln, input bit fld, input int seed);
    int ne;
    logic [7:0] exp;
    ne = (n > 2*s) ? n - 2*s : 0;
    chk(cap_n == ne, {tag, " byte count"}, cap_n, ne);
    for (int j = 0; j < ne && j < cap_n; j++) begin
      if (p && j == 0)      exp = 8'hFF;
      else if (p && j == 1) exp = guarded({fld, 5'(ln >> 4)});
      else if (p && j == 2) exp = guarded({2'b00, 4'(ln)});
      else if (p && j == 3) exp = 8'h00;
      else                  exp = 8'(seed + 2*s + j);
      chk(cap_b[j] == exp, {tag, " byte value"}, cap_b[j], exp);
      chk(cap_s[j] == (j == 0), {tag, " R9 start marker"}, cap_s[j], (j == 0));
    end
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0 && out_sol == 1'b0 && out_byte == 8'h00,
        "R8 outputs after reset", {out_byte, out_valid, out_sol}, 0);
    set_ctl(1, 1, 1, 0, 0, '1);
    cap_n = 0;
    hsync(100, 0, 0);
    feed(12, 0, 8'h20);
    chk(cap_n == 0, "R8 first line after reset not captured", cap_n, 0);
    cap_n = 0;
    hsync(100, 0, 0);
    feed(12, 0, 8'h20);
    expect_stream("R11 R12 second line captured", 0, 12, 0, 100, 0, 8'h20);
  endtask

  task automatic t_fields;
    run_line(1, 1, 0, 0, 0, '0, 50, 0, 0, 6, 0, 8'h30);
    expect_stream("R1 odd enabled odd line", 0, 6, 0, 50, 0, 8'h30);
    run_line(1, 1, 0, 0, 0, '0, 50, 1, 0, 6, 0, 8'h30);
    chk(cap_n == 0, "R1 even line with even disabled", cap_n, 0);
    run_line(0, 0, 1, 0, 0, 32'h0000_0100, 8, 1, 0, 6, 0, 8'h40);
    expect_stream("R1 even enabled in mask mode", 0, 6, 0, 8, 1, 8'h40);
    run_line(0, 0, 1, 0, 0, 32'h0000_0100, 8, 0, 0, 6, 0, 8'h40);
    chk(cap_n == 0, "R1 odd line in mask mode with odd disabled", cap_n, 0);
  endtask

  task automatic t_all_eq;
    run_line(1, 1, 1, 0, 0, '0, 3, 0, 1, 6, 0, 8'h50);
    chk(cap_n == 0, "R2 equalization line excluded", cap_n, 0);
    run_line(1, 1, 1, 0, 0, '0, 300, 1, 0, 6, 0, 8'h50);
    expect_stream("R2 high line in all-lines mode", 0, 6, 0, 300, 1, 8'h50);
  endtask

  task automatic t_mask;
    run_line(0, 1, 1, 0, 0, 32'h0000_0020, 5, 0, 1, 6, 0, 8'h60);
    expect_stream("R3 masked line captured despite eq flag", 0, 6, 0, 5, 0, 8'h60);
    run_line(0, 1, 1, 0, 0, 32'h0000_0020, 6, 0, 0, 6, 0, 8'h60);
    chk(cap_n == 0, "R3 unmasked line refused", cap_n, 0);
    run_line(0, 1, 1, 0, 0, 32'h0000_0020, 37, 0, 0, 6, 0, 8'h60);
    chk(cap_n == 0, "R3 line 37 aliasing bit 5 refused", cap_n, 0);
  endtask

  task automatic t_delay;
    run_line(1, 1, 1, 0, 3, '0, 40, 0, 0, 14, 1, 8'h70);
    expect_stream("R4 R12 start 3 with gapped strobe", 3, 14, 0, 40, 0, 8'h70);
    run_line(1, 1, 1, 0, 5, '0, 40, 0, 0, 9, 0, 8'h70);
    chk(cap_n == 0, "R4 line shorter than delay", cap_n, 0);
  endtask

  task automatic t_header;
    run_line(1, 1, 1, 1, 1, '0, 421, 1, 0, 12, 0, 8'h80);
    expect_stream("R5 R6 R7 header line 421 even", 1, 12, 1, 421, 1, 8'h80);
    chk(cap_n > 2 && cap_b[1] == 8'hBA && cap_b[2] == 8'h85,
        "R6 R7 header words 0xBA 0x85", {cap_b[1], cap_b[2]}, 16'hBA85);
    run_line(1, 1, 1, 1, 0, '0, 7, 0, 0, 8, 1, 8'h90);
    expect_stream("R5 R7 header line 7 odd", 0, 8, 1, 7, 0, 8'h90);
    chk(cap_n > 2 && cap_b[1] == 8'h80 && cap_b[2] == 8'h47,
        "R6 R7 header words 0x80 0x47", {cap_b[1], cap_b[2]}, 16'h8047);
  endtask

  task automatic t_stop;
    run_line(1, 1, 1, 0, 0, '0, 60, 0, 0, 5, 0, 8'hA0);
    hsync(61, 0, 1);
    feed(5, 0, 8'hB0);
    expect_stream("R10 capture ends at sync", 0, 5, 0, 60, 0, 8'hA0);
  endtask

  task automatic t_next_line;
    run_line(1, 1, 0, 0, 0, '0, 70, 0, 0, 4, 0, 8'hC0);
    set_ctl(1, 0, 0, 0, 0, '0);
    cap_n = 0;
    hsync(71, 0, 0);
    feed(4, 0, 8'hC0);
    expect_stream("R11 old controls still apply", 0, 4, 0, 71, 0, 8'hC0);
    cap_n = 0;
    hsync(72, 0, 0);
    feed(4, 0, 8'hC0);
    chk(cap_n == 0, "R11 new controls apply one line later", cap_n, 0);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_all_eq();
    t_mask();
    t_delay();
    t_header();
    t_stop();
    t_next_line();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule